// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block produces the processor-side bus strobes for one instruction fetch machine cycle. After a start request it puts the latched program counter on the address bus and drives the active-low fetch-marker and memory-request strobes. It then reads the opcode from the data bus and, in the second half of the same machine cycle, runs a read of a dynamic-memory refresh row. The states are T1, T2, any number of wait states and then T3 and T4. Strobe changes fall on both clock edges. The refresh half uses an internal 7-bit row counter, which is shown on the low address bits while the refresh strobe is active.

A slow memory stretches the fetch by holding the active-low wait input. The input is looked at on the falling edge in T2 and in every wait state, and each low sample adds one more wait state. When T4 ends, the block goes back to idle. If a start request is present at that edge, it begins the next T1 at once.

Top module: `opfetch_sequencer`

## Requirements
- R1: After reset, addr is zero, m1_n, mreq_n, rd_n and rfsh_n are high, done is low and the refresh row counter is zero.
- R2: A start sampled high on a rising edge while idle begins T1 at that edge: addr takes the pc value and m1_n goes low.
- R3: mreq_n and rd_n go low together on the falling edge inside T1 and stay low until the rising edge that begins T3.
- R4: The rising edge that begins T3 captures data_in into opcode, and done is high for exactly that one clock.
- R5: At the start of T3, m1_n returns high and rfsh_n goes low. Throughout T3 and T4, addr carries the refresh row in bits 6:0 and zero in bits 15:7.
- R6: rd_n stays high whenever rfsh_n is low.
- R7: In the refresh portion, mreq_n goes low on the falling edge inside T3 and high on the falling edge inside T4, and addr does not change while it is low.
- R8: wait_n is sampled on the falling edge in T2 and in each wait state. A low sample adds one wait state, so a fetch with n wait samples reaches T3 at 2+n clocks after T1 begins.
- R9: The refresh row counter advances by one at the end of each T4 and wraps from 127 to 0.
- R10: A start that is high on the rising edge ending T4 begins a new T1 at that edge with the new pc. Otherwise the block goes idle with rfsh_n high.
- R11: A start that arrives during T1, T2, a wait state or T3 is ignored, and addr keeps the pc latched when the fetch began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, both edges used |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a fetch cycle |
| pc | input | 16 | Program counter to fetch from |
| data_in | input | 8 | Data bus from memory |
| wait_n | input | 1 | Memory not ready, active low |
| addr | output | 16 | Address bus |
| m1_n | output | 1 | Fetch cycle marker, active low |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read enable, active low |
| rfsh_n | output | 1 | Refresh slot marker, active low |
| opcode | output | 8 | Captured opcode |
| done | output | 1 | One-clock pulse when opcode is valid |

## Verification
Two functions can fall on the same rising edge. The edge that ends T4 both moves the refresh row counter forward and, when start is held high, latches the next pc into a new T1. The bench provokes this with chained fetches and with a run of more than 128 fetches, so the counter wrap also coincides with a new T1. A behavioural model checks every output at the middle of both clock phases. This confirms that the old row stayed on addr until the refresh strobe was released, that the new T1 shows the new pc with rfsh_n already high, and that the next refresh shows the row advanced by exactly one.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    // state registered on the falling clock edge
    typedef struct packed {
        logic fetch_arm;   // fetch strobes enabled (set in T1)
        logic rf_strobe;   // refresh memory request pulse
        logic wait_ins;    // one more wait state requested
    } half_t;

    function automatic logic is_fetch(phase_e p);
        return (p == PH_T1) || (p == PH_T2) || (p == PH_TW);
    endfunction

    function automatic logic is_refresh(phase_e p);
        return (p == PH_T3) || (p == PH_T4);
    endfunction

endpackage

// File: rtl/opf_refresh_ctr.sv
module opf_refresh_ctr #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (adv) row_d = row_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

    p_row_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> row_q == ROW_W'($past(row_q) + 1'b1));

    p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row_q));

endmodule

// File: rtl/opf_half_cycle.sv
module opf_half_cycle
    import opf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   wait_n,
    output half_t  half
);
    half_t h_d, h_q;

    always_comb begin
        h_d           = '0;
        h_d.fetch_arm = is_fetch(phase);
        h_d.rf_strobe = (phase == PH_T3);
        h_d.wait_ins  = ((phase == PH_T2) || (phase == PH_TW)) && !wait_n;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign half = h_q;

    p_wait_only_fetch_r8: assert property (@(negedge clk) disable iff (!rst_n)
        h_q.wait_ins |-> h_q.fetch_arm);

    p_no_overlap_r7: assert property (@(negedge clk) disable iff (!rst_n)
        !(h_q.rf_strobe && h_q.fetch_arm));

endmodule

// File: rtl/opf_phase_fsm.sv
module opf_phase_fsm
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] data_in,
    input  logic              wait_ins,
    output phase_e            phase,
    output logic [ADDR_W-1:0] pc_lat,
    output logic [DATA_W-1:0] opcode,
    output logic              done,
    output logic              row_adv
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] op;
        logic              done;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE, PH_T4: begin
                if (start) begin
                    s_d.ph = PH_T1;
                    s_d.pc = pc;
                end else begin
                    s_d.ph = PH_IDLE;
                end
            end
            PH_T1: s_d.ph = PH_T2;
            PH_T2, PH_TW: begin
                if (wait_ins) begin
                    s_d.ph = PH_TW;
                end else begin
                    s_d.ph   = PH_T3;
                    s_d.op   = data_in;
                    s_d.done = 1'b1;
                end
            end
            PH_T3: s_d.ph = PH_T4;
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph   <= PH_IDLE;
            s_q.pc   <= '0;
            s_q.op   <= '0;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase   = s_q.ph;
    assign pc_lat  = s_q.pc;
    assign opcode  = s_q.op;
    assign done    = s_q.done;
    assign row_adv = (s_q.ph == PH_T4);

    p_start_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && start) |=> (s_q.ph == PH_T1 && s_q.pc == $past(pc)));

    p_wait_tw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.ph == PH_T2 || s_q.ph == PH_TW) && wait_ins) |=> s_q.ph == PH_TW);

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    p_pc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE && s_q.ph != PH_T4) |=> $stable(s_q.pc));

endmodule

// File: rtl/opfetch_sequencer.sv
module opfetch_sequencer
    import opf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] data_in,
    input  logic              wait_n,
    output logic [ADDR_W-1:0] addr,
    output logic              m1_n,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              rfsh_n,
    output logic [DATA_W-1:0] opcode,
    output logic              done
);
    localparam int HI_W = ADDR_W - ROW_W;

    phase_e            phase;
    half_t             half;
    logic [ADDR_W-1:0] pc_lat;
    logic [ROW_W-1:0]  row;
    logic              row_adv;
    logic              in_fetch, in_rf, fetch_req;

    opf_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .data_in(data_in),
        .wait_ins(half.wait_ins), .phase(phase), .pc_lat(pc_lat),
        .opcode(opcode), .done(done), .row_adv(row_adv)
    );

    opf_half_cycle u_half (
        .clk(clk), .rst_n(rst_n), .phase(phase), .wait_n(wait_n), .half(half)
    );

    opf_refresh_ctr #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(row)
    );

    always_comb begin
        in_fetch  = is_fetch(phase);
        in_rf     = is_refresh(phase);
        fetch_req = half.fetch_arm && in_fetch;
        if (in_fetch)   addr = pc_lat;
        else if (in_rf) addr = {{HI_W{1'b0}}, row};
        else            addr = '0;
        m1_n   = !in_fetch;
        rd_n   = !fetch_req;
        mreq_n = !(fetch_req || half.rf_strobe);
        rfsh_n = !in_rf;
    end

    p_rd_off_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> rd_n);

    p_m1_rfsh_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m1_n || rfsh_n);

    p_rd_with_mreq_r3: assert property (@(negedge clk) disable iff (!rst_n)
        !rd_n |-> !mreq_n);

    p_row_stable_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (!mreq_n && !rfsh_n) |-> $stable(addr));

endmodule

// File: tb/opfetch_sequencer_test.sv
`timescale 1ns/1ps
module opfetch_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc = '0;
    logic [7:0]  data_in = '0;
    logic        wait_n = 1'b1;
    logic [15:0] addr;
    logic        m1_n, mreq_n, rd_n, rfsh_n, done;
    logic [7:0]  opcode;

    int checks = 0;
    int errors = 0;
    int fcount = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    opfetch_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pc(pc), .data_in(data_in),
        .wait_n(wait_n), .addr(addr), .m1_n(m1_n), .mreq_n(mreq_n), .rd_n(rd_n),
        .rfsh_n(rfsh_n), .opcode(opcode), .done(done)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // behavioural reference: 0 idle,1 T1,2 T2,3 Tw,4 T3,5 T4
    int          mph = 0;
    int          mrow = 0;
    logic [15:0] mpc = '0;
    logic [7:0]  mop = '0;
    bit          mdone = 0, mwait = 0, marm = 0, mrfm = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mph = 0; mrow = 0; mpc = '0; mop = '0; mdone = 0;
        end else begin
            mdone = 0;
            if (mph == 5) mrow = (mrow + 1) % 128;
            if (mph == 0 || mph == 5) begin
                if (start) begin mph = 1; mpc = pc; end
                else mph = 0;
            end else if (mph == 1) mph = 2;
            else if (mph == 2 || mph == 3) begin
                if (mwait) mph = 3;
                else begin mph = 4; mop = data_in; mdone = 1; end
            end else if (mph == 4) mph = 5;
        end
    end

    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mwait = 0; marm = 0; mrfm = 0;
        end else begin
            mwait = (mph == 2 || mph == 3) && !wait_n;
            marm  = (mph >= 1 && mph <= 3);
            mrfm  = (mph == 4);
        end
    end

    task automatic compare_all();
        bit ef, er;
        ef = (mph >= 1 && mph <= 3);
        er = (mph == 4 || mph == 5);
        chk("R2 addr", addr, ef ? mpc : er ? 32'(mrow) : 0);
        chk("R2 m1_n", m1_n, !ef);
        chk("R6 rd_n", rd_n, !(marm && ef));
        chk("R7 mreq_n", mreq_n, !((marm && ef) || mrfm));
        chk("R5 rfsh_n", rfsh_n, !er);
        chk("R4 done", done, mdone);
        if (mdone) chk("R4 opcode", opcode, mop);
    endtask

    always @(posedge clk) begin #5; if (!finished) compare_all(); end
    always @(negedge clk) begin #5; if (!finished) compare_all(); end

    // one fetch; chained: request already presented by previous call
    task automatic do_fetch(logic [15:0] p, logic [7:0] d, int nw, bit noisy,
                            bit chained, bit chain_next, logic [15:0] next_pc);
        if (!chained) begin
            @(posedge clk); #2;
            start = 1; pc = p;
        end
        @(posedge clk); #2;                    // T1
        chk("R10 m1_n in T1", m1_n, 0);
        chk("R10 addr in T1", addr, p);
        data_in = d;
        if (noisy) begin start = 1; pc = ~p; end else start = 0;
        @(posedge clk); #2;                    // T2
        chk("R3 mreq_n in T2", mreq_n, 0);
        chk("R3 rd_n in T2", rd_n, 0);
        if (noisy) chk("R11 addr held", addr, p);
        wait_n = (nw == 0);
        for (int k = 0; k < nw; k++) begin
            @(posedge clk); #2;                // Tw
            chk("R8 still fetching", {m1_n, rfsh_n, rd_n}, 3'b010);
            wait_n = (k >= nw - 1);
        end
        @(posedge clk); #2;                    // T3
        wait_n = 1;
        chk("R8 done at T3", done, 1);
        chk("R4 opcode", opcode, d);
        chk("R9 refresh row", addr, 32'(fcount % 128));
        chk("R5 rfsh_n", rfsh_n, 0);
        if (noisy) chk("R11 addr refresh", addr[15:7], 0);
        fcount++;
        start = 0;
        @(posedge clk); #2;                    // T4
        chk("R6 rd_n in T4", rd_n, 1);
        if (chain_next) begin start = 1; pc = next_pc; end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #45;
        chk("R1 addr", addr, 0);
        chk("R1 strobes", {m1_n, mreq_n, rd_n, rfsh_n}, 4'hF);
        chk("R1 done", done, 0);
        @(posedge clk); #2; rst_n = 1;
        do_fetch(16'h1234, 8'hA5, 0, 0, 0, 0, 0);
        do_fetch(16'hBEEF, 8'h3C, 1, 0, 0, 0, 0);
        do_fetch(16'h0F0F, 8'h7E, 3, 1, 0, 0, 0);
        do_fetch(16'hFFFF, 8'h00, 2, 1, 0, 0, 0);
        // back-to-back chain
        do_fetch(16'h4000, 8'h11, 0, 0, 0, 1, 16'h4001);
        do_fetch(16'h4001, 8'h22, 1, 0, 1, 1, 16'h8002);
        do_fetch(16'h8002, 8'h33, 0, 0, 1, 0, 0);
        @(posedge clk); #2;
        chk("R10 idle after T4", {m1_n, rfsh_n, mreq_n}, 3'b111);
        // long chained run across the row counter wrap
        for (int i = 0; i < 130; i++)
            do_fetch(16'(i * 257), 8'(i), i % 3 == 0 ? 1 : 0, 0,
                     i != 0, i != 129, 16'((i + 1) * 257));
        @(posedge clk); #2;
        chk("R10 idle at end", addr, 0);
        #40;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule